// File: doc/BRIEF.md
# Sv39 Page-Table Walker

This block resolves a translation miss by reading a three-level Sv39 page table from memory. It takes a 39-bit virtual address, an access kind (fetch, load, store) and a privilege level, together with the root page number from the address-translation control register. It then issues one 8-byte read at a time on a simple request/response port, one read per level. When the walk stops at a valid leaf that passes every check, the block reports a 56-bit physical address and emits a refill record for a translation cache. Otherwise it reports a page-fault cause code. Leaves are honoured at any level, so 4 KiB pages, 2 MiB megapages and 1 GiB gigapages are all produced. For a superpage the low page-number fields of the result are taken from the virtual address.

The controller is a four-state machine. IDLE waits for `req_valid`. FETCH drives one read request for a single cycle. WAIT holds until `mem_rsp_valid` returns the entry. DONE presents the result for one cycle and then goes back to IDLE. Its transitions are:

- IDLE→FETCH when a translated request arrives.
- IDLE→DONE when the request is at machine privilege, which bypasses the walk.
- FETCH→WAIT always.
- WAIT→FETCH when the entry is a usable pointer to the next level.
- WAIT→DONE on a leaf or on a fault.
- DONE→IDLE always.

Top module: `sv39_walker`

## Requirements
- R1: The first read of a translated walk goes to byte address {root_ppn, VA[38:30], 3'b000}. Every read address has its low three bits at zero.
- R2: A valid entry with R=0 and X=0 is a pointer. The next read goes to {entry[53:10], VPN of the next lower level, 3'b000}. A walk issues at most three reads, and each request is a single-cycle pulse.
- R3: Entry bits are V=0, R=1, W=2, X=3, U=4, G=5, A=6, D=7, with the PPN in bits 53:10. A valid entry with R=1 or X=1 ends the walk as a leaf at the current level.
- R4: An entry with V=0, or with W=1 and R=0, raises a page fault.
- R5: A pointer entry fetched at level 0 raises a page fault. So does a pointer entry with any of D, A or U set.
- R6: A leaf at level 1 with PPN[8:0]≠0, or at level 2 with PPN[17:0]≠0, raises a page fault.
- R7: On success, PA[11:0]=VA[11:0]. Page-number fields below the leaf level come from the VA's VPN fields, and the rest come from the leaf's PPN.
- R8: A leaf with A=0 faults on any access. A leaf with D=0 faults on a store.
- R9: A fetch needs X, a load needs R and a store needs W. Privilege 0 (user) needs U=1. Privilege 1 or 2 (supervisor) needs U=0.
- R10: On a fault, `done_cause` is 12 for access 0 (fetch), 13 for access 1 (load), and 15 for access 2 or 3 (store/AMO).
- R11: At privilege 3 (machine) no read is issued. The result is the VA zero-extended to 56 bits, with no fault and no refill, reported in the cycle after acceptance.
- R12: `refill_valid` pulses with `done_valid` only on a successful translated walk. It carries VA[38:12], PA[55:12], the stop level and entry bits 7:0.
- R13: `done_valid` is a one-cycle pulse. A `req_valid` raised while `busy` is high is ignored.
- R14: After reset the block is idle, with `busy`, `mem_req_valid`, `done_valid` and `refill_valid` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a walk (taken only when idle) |
| req_vaddr | input | 39 | Virtual address |
| req_acc | input | 2 | Access kind: 0 fetch, 1 load, 2/3 store |
| req_priv | input | 2 | Privilege: 0 user, 1/2 supervisor, 3 machine |
| root_ppn | input | 44 | Root page-table page number |
| busy | output | 1 | Walk in progress |
| mem_req_valid | output | 1 | Entry read request pulse |
| mem_req_addr | output | 56 | Entry byte address |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_data | input | 64 | Page-table entry |
| done_valid | output | 1 | Result pulse |
| done_fault | output | 1 | Result is a page fault |
| done_cause | output | 4 | Fault cause code |
| done_paddr | output | 56 | Physical address |
| refill_valid | output | 1 | Translation-cache refill pulse |
| refill_vpn | output | 27 | Virtual page number |
| refill_ppn | output | 44 | Spliced physical page number |
| refill_level | output | 2 | Level at which the leaf was found |
| refill_perm | output | 8 | Leaf entry bits 7:0 |

## Verification
The bench builds a page table that contains all of the following:

- pages at each of the three levels
- a misaligned megapage and a misaligned gigapage
- a pointer entry at level 0 and a pointer entry with reserved bits set
- an invalid entry and a write-without-read entry
- leaves with A or D clear

A walker that splices the wrong VPN fields would return a wrong superpage address. One that ignored alignment would translate the misaligned superpages. One that kept descending at level 0 would issue a fourth read or hang. The bench counts reads per walk and checks the first read address, so a wrong root index or an extra read is visible. It also crosses access kind with privilege on the same pages, so an inverted U or X rule shows up as a wrong fault or cause code. A request raised mid-walk must leave the result unchanged.

// File: rtl/sv39_pkg.sv
package sv39_pkg;
    localparam int LEVELS   = 3;
    localparam int VPN_W    = 9;
    localparam int OFF_W    = 12;
    localparam int PPN_W    = 44;
    localparam int PTE_W    = 64;
    localparam int PTE_LG   = 3;
    localparam int VA_W     = OFF_W + LEVELS * VPN_W;
    localparam int PA_W     = OFF_W + PPN_W;
    localparam int LVL_W    = $clog2(LEVELS);
    localparam int CAUSE_W  = 4;

    localparam logic [1:0] ACC_FETCH = 2'd0;
    localparam logic [1:0] ACC_LOAD  = 2'd1;
    localparam logic [1:0] PRIV_U    = 2'd0;
    localparam logic [1:0] PRIV_M    = 2'd3;

    localparam logic [CAUSE_W-1:0] CAUSE_FETCH = 4'd12;
    localparam logic [CAUSE_W-1:0] CAUSE_LOAD  = 4'd13;
    localparam logic [CAUSE_W-1:0] CAUSE_STORE = 4'd15;

    typedef struct packed {
        logic [PTE_W-PPN_W-11:0] hi;
        logic [PPN_W-1:0]        ppn;
        logic [1:0]              rsw;
        logic                    d;
        logic                    a;
        logic                    g;
        logic                    u;
        logic                    x;
        logic                    w;
        logic                    r;
        logic                    v;
    } pte_t;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_FETCH = 2'd1,
        S_WAIT  = 2'd2,
        S_DONE  = 2'd3
    } walk_st_e;

    function automatic logic [CAUSE_W-1:0] cause_of(input logic [1:0] acc);
        if (acc == ACC_FETCH)     return CAUSE_FETCH;
        else if (acc == ACC_LOAD) return CAUSE_LOAD;
        else                      return CAUSE_STORE;
    endfunction
endpackage

// File: rtl/sv39_pte_decode.sv
module sv39_pte_decode
    import sv39_pkg::*;
(
    input  pte_t             pte,
    input  logic [LVL_W-1:0] level,
    output logic             is_bad,
    output logic             is_leaf,
    output logic             rsv_set,
    output logic             misaligned
);
    // R4: invalid or write-only encodings
    assign is_bad  = !pte.v || (pte.w && !pte.r);
    // R3: any of R or X marks a leaf
    assign is_leaf = pte.r || pte.x;
    // R5: reserved bits of a pointer entry
    assign rsv_set = pte.d || pte.a || pte.u;

    // R6: every PPN field below the stop level must be zero
    always_comb begin
        misaligned = 1'b0;
        for (int k = 0; k < LEVELS - 1; k++) begin
            if ((LVL_W'(k) < level) && (pte.ppn[k*VPN_W +: VPN_W] != '0))
                misaligned = 1'b1;
        end
    end

    logic unused_fields;
    assign unused_fields = ^{pte.hi, pte.rsw, pte.g, pte.ppn[PPN_W-1:(LEVELS-1)*VPN_W]};
endmodule

// File: rtl/sv39_perm_check.sv
module sv39_perm_check
    import sv39_pkg::*;
(
    input  logic       r,
    input  logic       w,
    input  logic       x,
    input  logic       u,
    input  logic       a,
    input  logic       d,
    input  logic [1:0] acc,
    input  logic [1:0] priv,
    output logic       deny
);
    logic need_ok;
    logic priv_bad;
    logic is_store;

    assign is_store = acc[1];

    // R9: the access kind selects the permission bit
    always_comb begin
        if (acc == ACC_FETCH)     need_ok = x;
        else if (acc == ACC_LOAD) need_ok = r;
        else                      need_ok = w;
    end

    // R9: user needs U set, supervisor needs U clear
    assign priv_bad = (priv == PRIV_U) ? !u : u;

    // R8: accessed / dirty rules
    assign deny = !need_ok || !a || (is_store && !d) || priv_bad;
endmodule

// File: rtl/sv39_pa_form.sv
module sv39_pa_form
    import sv39_pkg::*;
(
    input  logic [PPN_W-1:0] leaf_ppn,
    input  logic [VA_W-1:0]  vaddr,
    input  logic [LVL_W-1:0] level,
    output logic [PA_W-1:0]  paddr
);
    logic [PPN_W-1:0] ppn_mix;

    // R7: fields below the stop level come from the virtual address
    for (genvar k = 0; k < LEVELS - 1; k++) begin : g_fld
        assign ppn_mix[k*VPN_W +: VPN_W] = (LVL_W'(k) < level)
            ? vaddr[OFF_W + k*VPN_W +: VPN_W]
            : leaf_ppn[k*VPN_W +: VPN_W];
    end
    assign ppn_mix[PPN_W-1:(LEVELS-1)*VPN_W] = leaf_ppn[PPN_W-1:(LEVELS-1)*VPN_W];

    assign paddr = {ppn_mix, vaddr[OFF_W-1:0]};

    logic unused_top;
    assign unused_top = ^vaddr[VA_W-1:OFF_W + (LEVELS-1)*VPN_W];
endmodule

// File: rtl/sv39_walker.sv
module sv39_walker
    import sv39_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [38:0]         req_vaddr,
    input  logic [1:0]          req_acc,
    input  logic [1:0]          req_priv,
    input  logic [43:0]         root_ppn,
    output logic                busy,
    output logic                mem_req_valid,
    output logic [55:0]         mem_req_addr,
    input  logic                mem_rsp_valid,
    input  logic [63:0]         mem_rsp_data,
    output logic                done_valid,
    output logic                done_fault,
    output logic [3:0]          done_cause,
    output logic [55:0]         done_paddr,
    output logic                refill_valid,
    output logic [26:0]         refill_vpn,
    output logic [43:0]         refill_ppn,
    output logic [1:0]          refill_level,
    output logic [7:0]          refill_perm
);
    walk_st_e          st, st_nx;
    logic [LVL_W-1:0]  lvl_q;
    logic [PPN_W-1:0]  base_q;
    logic [VA_W-1:0]   va_q;
    logic [1:0]        acc_q;
    logic [1:0]        priv_q;
    logic              res_fault;
    logic              res_refill;
    logic [PA_W-1:0]   res_pa;
    logic [LVL_W-1:0]  res_lvl;
    logic [7:0]        res_perm;

    pte_t              pte;
    logic              pte_bad, pte_leaf, pte_rsv, pte_mis, perm_deny;
    logic              walk_down, walk_fault;
    logic [PA_W-1:0]   pa_formed;
    logic [VPN_W-1:0]  vpn_sel;

    assign pte = pte_t'(mem_rsp_data);

    sv39_pte_decode u_dec (
        .pte        (pte),
        .level      (lvl_q),
        .is_bad     (pte_bad),
        .is_leaf    (pte_leaf),
        .rsv_set    (pte_rsv),
        .misaligned (pte_mis)
    );

    sv39_perm_check u_perm (
        .r    (pte.r),
        .w    (pte.w),
        .x    (pte.x),
        .u    (pte.u),
        .a    (pte.a),
        .d    (pte.d),
        .acc  (acc_q),
        .priv (priv_q),
        .deny (perm_deny)
    );

    sv39_pa_form u_pa (
        .leaf_ppn (pte.ppn),
        .vaddr    (va_q),
        .level    (lvl_q),
        .paddr    (pa_formed)
    );

    // R2, R5: descend only on a clean pointer above level 0
    assign walk_down  = !pte_bad && !pte_leaf && !pte_rsv && (lvl_q != '0);
    assign walk_fault = pte_bad
                     || (pte_leaf && (pte_mis || perm_deny))
                     || (!pte_leaf && (pte_rsv || (lvl_q == '0)));

    assign vpn_sel = va_q[OFF_W + int'(lvl_q)*VPN_W +: VPN_W];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE:  if (req_valid) st_nx = (req_priv == PRIV_M) ? S_DONE : S_FETCH;
            S_FETCH: st_nx = S_WAIT;
            S_WAIT:  if (mem_rsp_valid) st_nx = walk_down ? S_FETCH : S_DONE;
            S_DONE:  st_nx = S_IDLE;
            default: st_nx = S_IDLE;
        endcase
    end

    // walk datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q      <= '0;
            base_q     <= '0;
            va_q       <= '0;
            acc_q      <= '0;
            priv_q     <= '0;
            res_fault  <= 1'b0;
            res_refill <= 1'b0;
            res_pa     <= '0;
            res_lvl    <= '0;
            res_perm   <= '0;
        end else begin
            if (st == S_IDLE && req_valid) begin
                va_q       <= req_vaddr;
                acc_q      <= req_acc;
                priv_q     <= req_priv;
                base_q     <= root_ppn;
                lvl_q      <= LVL_W'(LEVELS - 1);
                res_refill <= 1'b0;
                res_fault  <= 1'b0;
                res_pa     <= PA_W'(req_vaddr);
            end else if (st == S_WAIT && mem_rsp_valid) begin
                if (walk_down) begin
                    base_q <= pte.ppn;
                    lvl_q  <= lvl_q - 1'b1;
                end else begin
                    res_fault  <= walk_fault;
                    res_refill <= !walk_fault;
                    res_pa     <= pa_formed;
                    res_lvl    <= lvl_q;
                    res_perm   <= mem_rsp_data[7:0];
                end
            end
        end
    end

    // outputs
    always_comb begin
        busy          = (st != S_IDLE);
        mem_req_valid = (st == S_FETCH);
        mem_req_addr  = {base_q, vpn_sel, {PTE_LG{1'b0}}};
        done_valid    = (st == S_DONE);
        done_fault    = done_valid && res_fault;
        done_cause    = done_fault ? cause_of(acc_q) : '0;
        done_paddr    = res_pa;
        refill_valid  = done_valid && res_refill;
        refill_vpn    = va_q[VA_W-1:OFF_W];
        refill_ppn    = res_pa[PA_W-1:OFF_W];
        refill_level  = res_lvl;
        refill_perm   = res_perm;
    end
endmodule

// File: rtl/sv39_walker_chk.sv
module sv39_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        mem_req_valid,
    input logic [55:0] mem_req_addr,
    input logic        done_valid,
    input logic        done_fault,
    input logic [3:0]  done_cause,
    input logic [55:0] done_paddr,
    input logic        refill_valid,
    input logic [43:0] refill_ppn
);
    // R1
    entry_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[2:0] == 3'b000));

    // R2
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);

    // R13
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);

    // R10
    cause_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_fault |-> (done_cause == 4'd12 || done_cause == 4'd13 || done_cause == 4'd15));

    // R12
    refill_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refill_valid |-> (done_valid && !done_fault && refill_ppn == done_paddr[55:12]));

    // R14
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req_valid && !done_valid));

    // R11
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && !done_fault && !refill_valid) |-> (done_paddr[55:39] == '0));
endmodule

bind sv39_walker sv39_walker_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy          (busy),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .done_valid    (done_valid),
    .done_fault    (done_fault),
    .done_cause    (done_cause),
    .done_paddr    (done_paddr),
    .refill_valid  (refill_valid),
    .refill_ppn    (refill_ppn)
);

// File: tb/tb_sv39_walker.sv
`timescale 1ns/1ps
module tb_sv39_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [38:0] req_vaddr = '0;
    logic [1:0]  req_acc = '0;
    logic [1:0]  req_priv = '0;
    logic [43:0] root_ppn = 44'h100;
    logic        busy, mem_req_valid, mem_rsp_valid;
    logic [55:0] mem_req_addr;
    logic [63:0] mem_rsp_data;
    logic        done_valid, done_fault, refill_valid;
    logic [3:0]  done_cause;
    logic [55:0] done_paddr;
    logic [26:0] refill_vpn;
    logic [43:0] refill_ppn;
    logic [1:0]  refill_level;
    logic [7:0]  refill_perm;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    sv39_walker dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_acc(req_acc), .req_priv(req_priv), .root_ppn(root_ppn), .busy(busy),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done_valid(done_valid), .done_fault(done_fault), .done_cause(done_cause),
        .done_paddr(done_paddr), .refill_valid(refill_valid), .refill_vpn(refill_vpn),
        .refill_ppn(refill_ppn), .refill_level(refill_level), .refill_perm(refill_perm)
    );

    logic [63:0] pmem [logic [55:0]];

    function automatic logic [63:0] mk(input logic [43:0] ppn, input logic [7:0] fl);
        return {10'b0, ppn, 2'b0, fl};
    endfunction

    function automatic logic [63:0] rd(input logic [55:0] a);
        if (pmem.exists(a)) return pmem[a];
        return 64'h0;
    endfunction

    typedef struct packed {
        logic [38:0] va;
        logic [1:0]  acc;
        logic [1:0]  priv;
        logic        flt;
        logic [3:0]  cause;
        logic [55:0] pa;
        logic [1:0]  reads;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{39'h0000001ABC, 2'd1, 2'd1, 1'b0, 4'd0,  56'h80001ABC,   2'd3}, // R7 4K load
        '{39'h0000001ABC, 2'd2, 2'd1, 1'b0, 4'd0,  56'h80001ABC,   2'd3}, // R9 store ok
        '{39'h0000001ABC, 2'd0, 2'd1, 1'b1, 4'd12, 56'h0,          2'd3}, // R9 no X
        '{39'h0000001ABC, 2'd1, 2'd0, 1'b1, 4'd13, 56'h0,          2'd3}, // R9 user on S page
        '{39'h0000002010, 2'd0, 2'd0, 1'b0, 4'd0,  56'h80002010,   2'd3}, // R9 user fetch
        '{39'h0000002010, 2'd1, 2'd1, 1'b1, 4'd13, 56'h0,          2'd3}, // R9 sup on U page
        '{39'h0000002010, 2'd2, 2'd0, 1'b1, 4'd15, 56'h0,          2'd3}, // R9 no W
        '{39'h0000003000, 2'd1, 2'd1, 1'b1, 4'd13, 56'h0,          2'd3}, // R4 V=0
        '{39'h0000004000, 2'd1, 2'd1, 1'b1, 4'd13, 56'h0,          2'd3}, // R4 W no R
        '{39'h0000005000, 2'd1, 2'd1, 1'b0, 4'd0,  56'h80005000,   2'd3}, // R8 load D=0 ok
        '{39'h0000005000, 2'd2, 2'd1, 1'b1, 4'd15, 56'h0,          2'd3}, // R8 store D=0
        '{39'h0000006000, 2'd1, 2'd1, 1'b1, 4'd13, 56'h0,          2'd3}, // R8 A=0
        '{39'h0000007000, 2'd1, 2'd1, 1'b1, 4'd13, 56'h0,          2'd3}, // R5 pointer at L0
        '{39'h0000205123, 2'd0, 2'd1, 1'b0, 4'd0,  56'h80205123,   2'd2}, // R7 megapage
        '{39'h0000400000, 2'd1, 2'd1, 1'b1, 4'd13, 56'h0,          2'd2}, // R6 mega misaligned
        '{39'h0000600000, 2'd2, 2'd1, 1'b1, 4'd15, 56'h0,          2'd2}, // R5 reserved A
        '{39'h0080607456, 2'd0, 2'd0, 1'b0, 4'd0,  56'h80607456,   2'd1}, // R7 gigapage
        '{39'h00C0000000, 2'd1, 2'd1, 1'b1, 4'd13, 56'h0,          2'd1}, // R6 giga misaligned
        '{39'h0040000000, 2'd0, 2'd1, 1'b1, 4'd12, 56'h0,          2'd1}, // R10 fetch cause
        '{39'h7FFFFFF123, 2'd2, 2'd3, 1'b0, 4'd0,  56'h7FFFFFF123, 2'd0}  // R11 bypass
    };

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    logic [55:0] first_addr;
    int          nreads;
    logic        got_done, r_fault, r_refill;
    logic [3:0]  r_cause;
    logic [55:0] r_pa;
    logic [1:0]  r_lvl;

    task automatic run_walk(input vec_t v, input bit inject);
        bit pend = 0;
        bit injected = 0;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = v.va; req_acc = v.acc; req_priv = v.priv;
        @(negedge clk);
        req_valid = 1'b0;
        nreads = 0; got_done = 0; first_addr = '0;
        for (int c = 0; c < 40 && !got_done; c++) begin
            mem_rsp_valid = 1'b0;
            if (injected) req_valid = 1'b0;
            if (done_valid) begin
                got_done = 1; r_fault = done_fault; r_cause = done_cause;
                r_pa = done_paddr; r_refill = refill_valid; r_lvl = refill_level;
            end else if (mem_req_valid) begin
                if (nreads == 0) first_addr = mem_req_addr;
                nreads++;
                mem_rsp_data = rd(mem_req_addr);
                pend = 1;
            end else if (pend) begin
                mem_rsp_valid = 1'b1;
                pend = 0;
                if (inject && !injected) begin
                    req_valid = 1'b1; req_vaddr = 39'h3000; req_acc = 2'd2; injected = 1;
                end
            end
            if (!got_done) @(negedge clk);
        end
        mem_rsp_valid = 1'b0;
        req_valid = 1'b0;
    endtask

    task automatic check_vec(input vec_t v, input string tag);
        check(got_done, {tag, " done pulse R13"}, 64'(got_done), 64'd1);
        check(nreads == int'(v.reads), {tag, " read count R2"}, 64'(nreads), 64'(v.reads));
        if (v.reads != 0)
            check(first_addr == {44'h100, v.va[38:30], 3'b000}, {tag, " root address R1"},
                  64'(first_addr), 64'({44'h100, v.va[38:30], 3'b000}));
        check(r_fault == v.flt, {tag, " fault flag R3"}, 64'(r_fault), 64'(v.flt));
        if (v.flt)
            check(r_cause == v.cause, {tag, " cause R10"}, 64'(r_cause), 64'(v.cause));
        else
            check(r_pa == v.pa, {tag, " paddr R7"}, 64'(r_pa), 64'(v.pa));
        check(r_refill == (!v.flt && v.priv != 2'd3), {tag, " refill R12"},
              64'(r_refill), 64'(!v.flt && v.priv != 2'd3));
        if (r_refill)
            check(r_lvl == 2'(3 - int'(v.reads)), {tag, " refill level R12"},
                  64'(r_lvl), 64'(3 - int'(v.reads)));
    endtask

    initial begin
        #(4 * 20000);
        fails++; tests++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        pmem[56'h100000] = mk(44'h101,   8'h01);
        pmem[56'h100010] = mk(44'h80000, 8'hDB);
        pmem[56'h100018] = mk(44'h80100, 8'hC3);
        pmem[56'h101000] = mk(44'h102,   8'h01);
        pmem[56'h101008] = mk(44'h80200, 8'hCF);
        pmem[56'h101010] = mk(44'h80201, 8'hC7);
        pmem[56'h101018] = mk(44'h103,   8'h41);
        pmem[56'h102008] = mk(44'h80001, 8'hC7);
        pmem[56'h102010] = mk(44'h80002, 8'h5B);
        pmem[56'h102020] = mk(44'h80004, 8'hC5);
        pmem[56'h102028] = mk(44'h80005, 8'h47);
        pmem[56'h102030] = mk(44'h80006, 8'h03);
        pmem[56'h102038] = mk(44'h103,   8'h01);

        repeat (3) @(negedge clk);
        // R14 reset state
        check({busy, mem_req_valid, done_valid, refill_valid} == 4'b0, "R14 reset outputs",
              64'({busy, mem_req_valid, done_valid, refill_valid}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy, "R14 idle after reset", 64'(busy), 64'd0);

        for (int i = 0; i < NV; i++) begin
            run_walk(VECS[i], 1'b0);
            check_vec(VECS[i], $sformatf("vec%0d", i));
            @(negedge clk);
            check(!busy && !done_valid, "R13 back to idle", 64'({busy, done_valid}), 64'd0);
        end

        // R13: a request raised mid-walk is ignored
        run_walk(VECS[0], 1'b1);
        check_vec(VECS[0], "busy-inject");
        @(negedge clk);
        check(!busy, "R13 no second walk started", 64'(busy), 64'd0);

        // R11: machine access bypass cycle count and no reads
        run_walk(VECS[NV-1], 1'b0);
        check(nreads == 0 && got_done, "R11 no reads in bypass", 64'(nreads), 64'd0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule